// File: doc/BRIEF.md
# Direction-Switchable Message Queue Controller

This block manages a single message queue for a CAN controller. Software decides whether the queue transmits or receives. The queue holds between 1 and 32 message slots, and each slot has a selectable payload size. The block keeps a producer index (head) and a consumer index (tail) into message RAM. It keeps an occupancy counter and derives empty, half and full status from it. It also raises an interrupt line from status sources that change meaning with the direction.

When the queue transmits, software fills a slot and pulses the increment strobe. It then raises a send request. A protocol engine answers with "sent" and "attempt failed" pulses. The request clears by itself once the queue drains or the retry budget runs out. Software can withdraw the request, and the block then signals an abort. When the queue receives, the engine's "received" pulses fill it. Software frees slots with the same increment strobe. A receive pulse that arrives while the queue is full is dropped and sets a sticky overflow flag. A self-clearing reset command empties the queue. Writes to the geometry and direction fields take effect only in configuration mode.

Top module: `msg_fifo_ctl`

## Requirements
- R1: Depth equals the 5-bit depth field (ctrl bits 7:3) plus one. The head and tail indices step from depth-1 back to 0. `statusFull` is high when occupancy reaches the depth, and `statusEmpty` is high when occupancy is 0.
- R2: `payloadBytes` decodes the 3-bit payload field (ctrl bits 2:0) as codes 0 to 7 giving 8, 12, 16, 20, 24, 32, 48 and 64 bytes.
- R3: Payload, depth and direction (ctrl bit 8, 1 = transmit) change only on a write made while `opMode` is 3'b100. Otherwise the write leaves them unchanged.
- R4: A write with bit 23 set advances the head in transmit mode and the tail in receive mode, one cycle later. It is ignored when the move would pass full (head) or empty (tail). Bit 23 always reads back as 0.
- R5: The reset-command bit (ctrl bit 21) is 1 after reset. Writing 1 to it empties the queue on the next clock edge: both indices and occupancy go to 0, and the overflow, exhausted and request flags clear. The bit then reads 0 again.
- R6: In transmit mode, writing bit 22 as 1 raises `txRequest`. A "sent" pulse that removes the last queued message clears it.
- R7: In transmit mode, a write with bit 22 at 0 while `txRequest` is 1 clears the request and pulses `abortReq` for one cycle. In receive mode, writes to bit 22 have no effect.
- R8: In transmit mode, a remote-frame pulse sets `txRequest` when the auto-reply enable (ctrl bit 24) is 1, and leaves it unchanged when that bit is 0.
- R9: Retry field (ctrl bits 10:9, reset value 11): 00 ends the request on the first failed attempt, 01 ends it on the fourth (three retries), and 10/11 never end it. Ending the request clears `txRequest` and sets `exhaustedFlag`.
- R10: `irq` is the OR of the enabled sources. Bit 16 gates empty (transmit) or full (receive). Bit 17 gates half-empty (transmit) or half-full (receive). Bit 18 gates not-full (transmit) or not-empty (receive). Bit 19 gates overflow and bit 20 gates exhausted.
- R11: A receive pulse while full sets `overflowFlag` and leaves the head and occupancy unchanged.
- R12: `statusHalf` is high when occupancy is at least ceil(depth/2). Half-empty in transmit mode is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opMode | input | 3 | Controller operating mode; 3'b100 is configuration |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 32 | Control word write value |
| ctrlRd | output | 32 | Control word read-back |
| sentPulse | input | 1 | Engine finished sending one message |
| rxPulse | input | 1 | Engine received one message |
| remotePulse | input | 1 | Engine saw a remote frame for this queue |
| failPulse | input | 1 | Engine transmit attempt failed |
| headIdx | output | 5 | Producer slot index |
| tailIdx | output | 5 | Consumer slot index |
| occupancy | output | 6 | Messages currently queued |
| payloadBytes | output | 7 | Bytes per slot |
| txPriority | output | 5 | Transmit priority field (bits 15:11) |
| txRequest | output | 1 | Send request to the engine |
| abortReq | output | 1 | One-cycle abort request |
| statusEmpty | output | 1 | Queue empty |
| statusHalf | output | 1 | Occupancy at least half the depth |
| statusFull | output | 1 | Queue full |
| overflowFlag | output | 1 | Sticky receive overflow |
| exhaustedFlag | output | 1 | Sticky retries exhausted |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. Full and empty never hold together. The geometry and direction fields stay frozen outside configuration mode. A reset command leaves both indices at zero. An abort never coexists with a live request, and a request never rises in receive mode. A receive pulse into a full queue sets overflow and leaves the head in place. A zero-retry failure ends the request. The bench scenarios cover the rest: the order of index wrap-around, auto-clear on drain, the three-retry count, remote-frame setting, payload decoding, and how the interrupt sources swap meaning with direction.

// File: rtl/msg_fifo_pkg.sv
package msg_fifo_pkg;
  localparam int DEPTH_W     = 5;
  localparam int PAY_W       = 3;
  localparam int IE_W        = 5;
  localparam int RETRY_LIMIT = 3;
  localparam int FAIL_W      = $clog2(RETRY_LIMIT + 1);
  localparam logic [2:0] CFG_MODE = 3'b100;

  localparam int PAY_LSB   = 0;
  localparam int DEP_LSB   = PAY_LSB + PAY_W;
  localparam int DIR_BIT   = DEP_LSB + DEPTH_W;
  localparam int RETRY_LSB = DIR_BIT + 1;
  localparam int PRIO_LSB  = RETRY_LSB + 2;
  localparam int IE_LSB    = PRIO_LSB + 5;
  localparam int RST_BIT   = IE_LSB + IE_W;
  localparam int REQ_BIT   = RST_BIT + 1;
  localparam int INC_BIT   = REQ_BIT + 1;
  localparam int RTR_BIT   = INC_BIT + 1;

  typedef struct packed {
    logic clear;
    logic headAdv;
    logic tailAdv;
  } ptrStrobe_t;

  function automatic logic [6:0] decodePayload(input logic [PAY_W-1:0] code);
    logic [6:0] bytes;
    case (code)
      3'd5:    bytes = 7'd32;
      3'd6:    bytes = 7'd48;
      3'd7:    bytes = 7'd64;
      default: bytes = 7'd8 + {2'b0, code, 2'b0};
    endcase
    return bytes;
  endfunction
endpackage

// File: rtl/msg_fifo_ptrs.sv
module msg_fifo_ptrs
  import msg_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ptrStrobe_t         strobe,
  input  logic [DEPTH_W-1:0] depthCode,
  output logic [DEPTH_W-1:0] headIdx,
  output logic [DEPTH_W-1:0] tailIdx,
  output logic [DEPTH_W:0]   occupancy,
  output logic               isFull,
  output logic               isEmpty,
  output logic               isHalf,
  output logic               isOne
);
  logic [DEPTH_W:0] depth;
  logic [DEPTH_W:0] halfMark;

  assign depth    = {1'b0, depthCode} + 1'b1;
  assign halfMark = (depth + 1'b1) >> 1;
  assign isFull   = occupancy >= depth;
  assign isEmpty  = occupancy == '0;
  assign isHalf   = occupancy >= halfMark;
  assign isOne    = occupancy == 1;

  function automatic logic [DEPTH_W-1:0] stepIdx(input logic [DEPTH_W-1:0] idx,
                                                  input logic [DEPTH_W-1:0] last);
    return (idx >= last) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      occupancy <= '0;
    end else if (strobe.clear) begin
      headIdx   <= '0;
      tailIdx   <= '0;
      occupancy <= '0;
    end else begin
      if (strobe.headAdv) headIdx <= stepIdx(headIdx, depthCode);
      if (strobe.tailAdv) tailIdx <= stepIdx(tailIdx, depthCode);
      case ({strobe.headAdv, strobe.tailAdv})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end
endmodule

// File: rtl/msg_fifo_ctl_regs.sv
module msg_fifo_ctl_regs
  import msg_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         opMode,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  input  logic               sentPulse,
  input  logic               rxPulse,
  input  logic               remotePulse,
  input  logic               failPulse,
  input  logic               isFull,
  input  logic               isEmpty,
  input  logic               isHalf,
  input  logic               isOne,
  output ptrStrobe_t         strobe,
  output logic [DEPTH_W-1:0] depthCode,
  output logic [6:0]         payloadBytes,
  output logic [4:0]         txPriority,
  output logic               txRequest,
  output logic               abortReq,
  output logic               overflowFlag,
  output logic               exhaustedFlag,
  output logic               irq,
  output logic [31:0]        ctrlRd
);
  logic [PAY_W-1:0]  payCode;
  logic              dirTx;
  logic [1:0]        retryMode;
  logic [IE_W-1:0]   intEn;
  logic              rtrEn;
  logic              resetFlag;
  logic [FAIL_W-1:0] failCnt;

  logic cfgOpen, wrInc, wrReq, wrRst;
  logic drainDone, failEvent, exhaustNow, ovfEvent, reqSetNow;
  logic srcA, srcB, srcC;
  logic [6:0] unusedWrBits;

  assign unusedWrBits = wrData[31:RTR_BIT+1];
  assign cfgOpen = opMode == CFG_MODE;
  assign wrInc   = wrEn & wrData[INC_BIT];
  assign wrReq   = wrData[REQ_BIT];
  assign wrRst   = wrEn & wrData[RST_BIT];

  // pointer strobes toward the datapath
  always_comb begin
    strobe = '0;
    strobe.clear = resetFlag;
    if (!resetFlag) begin
      if (dirTx) begin
        strobe.headAdv = wrInc & ~isFull;
        strobe.tailAdv = sentPulse & ~isEmpty;
      end else begin
        strobe.headAdv = rxPulse & ~isFull;
        strobe.tailAdv = wrInc & ~isEmpty;
      end
    end
  end

  assign drainDone  = dirTx & strobe.tailAdv & ~strobe.headAdv & isOne;
  assign ovfEvent   = ~dirTx & rxPulse & isFull & ~resetFlag;
  assign failEvent  = dirTx & txRequest & failPulse & ~resetFlag;
  assign exhaustNow = failEvent &
                      ((retryMode == 2'b00) ||
                       (retryMode == 2'b01 && failCnt == FAIL_W'(RETRY_LIMIT)));
  assign reqSetNow  = dirTx & wrEn & wrReq & ~txRequest;

  // configuration fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      payCode    <= '0;
      depthCode  <= '0;
      dirTx      <= 1'b0;
      retryMode  <= 2'b11;
      txPriority <= '0;
      intEn      <= '0;
      rtrEn      <= 1'b0;
    end else if (wrEn) begin
      if (cfgOpen) begin
        payCode   <= wrData[PAY_LSB +: PAY_W];
        depthCode <= wrData[DEP_LSB +: DEPTH_W];
        dirTx     <= wrData[DIR_BIT];
      end
      retryMode  <= wrData[RETRY_LSB +: 2];
      txPriority <= wrData[PRIO_LSB +: 5];
      intEn      <= wrData[IE_LSB +: IE_W];
      rtrEn      <= wrData[RTR_BIT];
    end
  end

  // reset command, request handshake and sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resetFlag     <= 1'b1;
      txRequest     <= 1'b0;
      abortReq      <= 1'b0;
      overflowFlag  <= 1'b0;
      exhaustedFlag <= 1'b0;
      failCnt       <= '0;
    end else begin
      resetFlag <= wrRst;
      abortReq  <= 1'b0;
      if (resetFlag) begin
        txRequest     <= 1'b0;
        overflowFlag  <= 1'b0;
        exhaustedFlag <= 1'b0;
        failCnt       <= '0;
      end else begin
        if (ovfEvent)   overflowFlag  <= 1'b1;
        if (exhaustNow) exhaustedFlag <= 1'b1;

        if (reqSetNow || (dirTx && sentPulse)) failCnt <= '0;
        else if (failEvent && failCnt != FAIL_W'(RETRY_LIMIT)) failCnt <= failCnt + 1'b1;

        if (dirTx) begin
          if (wrEn) begin
            if (wrReq) txRequest <= 1'b1;
            else if (txRequest) begin
              txRequest <= 1'b0;
              abortReq  <= 1'b1;
            end
          end else if (remotePulse && rtrEn) begin
            txRequest <= 1'b1;
          end else if (exhaustNow || drainDone) begin
            txRequest <= 1'b0;
          end
        end
      end
    end
  end

  // interrupt sources swap meaning with direction
  assign srcA = dirTx ? isEmpty : isFull;
  assign srcB = dirTx ? ~isHalf : isHalf;
  assign srcC = dirTx ? ~isFull : ~isEmpty;
  assign irq  = |(intEn & {exhaustedFlag, overflowFlag, srcC, srcB, srcA});

  assign payloadBytes = decodePayload(payCode);
  assign ctrlRd = {7'b0, rtrEn, 1'b0, txRequest, resetFlag, intEn, txPriority,
                   retryMode, dirTx, depthCode, payCode};
endmodule

// File: rtl/msg_fifo_ctl.sv
module msg_fifo_ctl
  import msg_fifo_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         opMode,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        ctrlRd,
  input  logic               sentPulse,
  input  logic               rxPulse,
  input  logic               remotePulse,
  input  logic               failPulse,
  output logic [DEPTH_W-1:0] headIdx,
  output logic [DEPTH_W-1:0] tailIdx,
  output logic [DEPTH_W:0]   occupancy,
  output logic [6:0]         payloadBytes,
  output logic [4:0]         txPriority,
  output logic               txRequest,
  output logic               abortReq,
  output logic               statusEmpty,
  output logic               statusHalf,
  output logic               statusFull,
  output logic               overflowFlag,
  output logic               exhaustedFlag,
  output logic               irq
);
  ptrStrobe_t         strobe;
  logic [DEPTH_W-1:0] depthCode;
  logic               isOne;

  msg_fifo_ctl_regs u_regs (
    .clk(clk), .rstN(rstN), .opMode(opMode), .wrEn(wrEn), .wrData(wrData),
    .sentPulse(sentPulse), .rxPulse(rxPulse), .remotePulse(remotePulse),
    .failPulse(failPulse), .isFull(statusFull), .isEmpty(statusEmpty),
    .isHalf(statusHalf), .isOne(isOne), .strobe(strobe), .depthCode(depthCode),
    .payloadBytes(payloadBytes), .txPriority(txPriority), .txRequest(txRequest),
    .abortReq(abortReq), .overflowFlag(overflowFlag),
    .exhaustedFlag(exhaustedFlag), .irq(irq), .ctrlRd(ctrlRd)
  );

  msg_fifo_ptrs u_ptrs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .depthCode(depthCode),
    .headIdx(headIdx), .tailIdx(tailIdx), .occupancy(occupancy),
    .isFull(statusFull), .isEmpty(statusEmpty), .isHalf(statusHalf), .isOne(isOne)
  );
endmodule

// File: rtl/msg_fifo_ctl_chk.sv
module msg_fifo_ctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  opMode,
  input logic        wrEn,
  input logic [31:0] ctrlRd,
  input logic        rxPulse,
  input logic        remotePulse,
  input logic        failPulse,
  input logic [4:0]  headIdx,
  input logic [4:0]  tailIdx,
  input logic [5:0]  occupancy,
  input logic        txRequest,
  input logic        abortReq,
  input logic        statusEmpty,
  input logic        statusFull,
  input logic        overflowFlag,
  input logic        exhaustedFlag
);
  // R1
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(statusFull && statusEmpty));

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode != 3'b100) |=> (ctrlRd[8:0] == $past(ctrlRd[8:0])));

  // R5
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[21] |=> (occupancy == 6'd0 && headIdx == 5'd0 && tailIdx == 5'd0));

  // R7
  abort_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> !txRequest);

  // R7
  rx_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRequest) |-> $past(ctrlRd[8]));

  // R9
  zero_retry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[10:9] == 2'b00 && ctrlRd[8] && txRequest && failPulse && !wrEn &&
     !remotePulse && !ctrlRd[21]) |=> (!txRequest && exhaustedFlag));

  // R11
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[8] && statusFull && rxPulse && !ctrlRd[21]) |=> (overflowFlag && $stable(headIdx)));
endmodule

bind msg_fifo_ctl msg_fifo_ctl_chk u_chk (.*);

// File: tb/msg_fifo_ctl_bench.sv
module msg_fifo_ctl_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 11;

  typedef struct packed {
    logic        wr;
    logic [31:0] data;
    logic [2:0]  mode;
    logic        sent;
    logic [5:0]  occ;
    logic [4:0]  head;
    logic [4:0]  tail;
    logic        full;
    logic        empty;
    logic        req;
    logic        irq;
  } vec_t;

  // transmit queue, depth 4, empty interrupt enabled (R1 R4 R6 R10)
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 32'h00012B1A, 3'b100, 1'b0, 6'd0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 32'h00892B1A, 3'b000, 1'b0, 6'd1, 5'd1, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h00892B1A, 3'b000, 1'b0, 6'd2, 5'd2, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h00892B1A, 3'b000, 1'b0, 6'd3, 5'd3, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h00892B1A, 3'b000, 1'b0, 6'd4, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h00892B1A, 3'b000, 1'b0, 6'd4, 5'd0, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h00412B1A, 3'b000, 1'b0, 6'd4, 5'd0, 5'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 32'h00000000, 3'b000, 1'b1, 6'd3, 5'd0, 5'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 32'h00000000, 3'b000, 1'b1, 6'd2, 5'd0, 5'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 32'h00000000, 3'b000, 1'b1, 6'd1, 5'd0, 5'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 32'h00000000, 3'b000, 1'b1, 6'd0, 5'd0, 5'd0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] opMode = '0;
  logic wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic sentPulse = 1'b0, rxPulse = 1'b0, remotePulse = 1'b0, failPulse = 1'b0;
  logic [31:0] ctrlRd;
  logic [4:0] headIdx, tailIdx, txPriority;
  logic [5:0] occupancy;
  logic [6:0] payloadBytes;
  logic txRequest, abortReq, statusEmpty, statusHalf, statusFull;
  logic overflowFlag, exhaustedFlag, irq;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  msg_fifo_ctl u_msg_fifo_ctl (
    .clk(clk), .rstN(rstN), .opMode(opMode), .wrEn(wrEn), .wrData(wrData),
    .ctrlRd(ctrlRd), .sentPulse(sentPulse), .rxPulse(rxPulse),
    .remotePulse(remotePulse), .failPulse(failPulse), .headIdx(headIdx),
    .tailIdx(tailIdx), .occupancy(occupancy), .payloadBytes(payloadBytes),
    .txPriority(txPriority), .txRequest(txRequest), .abortReq(abortReq),
    .statusEmpty(statusEmpty), .statusHalf(statusHalf), .statusFull(statusFull),
    .overflowFlag(overflowFlag), .exhaustedFlag(exhaustedFlag), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at the falling edge, sample just after the next rising edge
  task automatic step(input logic w, input logic [31:0] d, input logic [2:0] m,
                      input logic s, input logic r, input logic rt, input logic f);
    @(negedge clk);
    wrEn = w; wrData = d; opMode = m;
    sentPulse = s; rxPulse = r; remotePulse = rt; failPulse = f;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset value of control word", ctrlRd, 32'h00200600);
    check("R1 empty at reset", {26'b0, occupancy}, 32'd0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check("R5 reset command self-clears", ctrlRd, 32'h00000600);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].data, VEC[i].mode, VEC[i].sent, 1'b0, 1'b0, 1'b0);
      check($sformatf("R1 R4 occupancy row %0d", i), {26'b0, occupancy}, {26'b0, VEC[i].occ});
      check($sformatf("R1 R4 head row %0d", i), {27'b0, headIdx}, {27'b0, VEC[i].head});
      check($sformatf("R1 tail row %0d", i), {27'b0, tailIdx}, {27'b0, VEC[i].tail});
      check($sformatf("R1 full/empty row %0d", i), {30'b0, statusFull, statusEmpty},
            {30'b0, VEC[i].full, VEC[i].empty});
      check($sformatf("R6 request row %0d", i), {31'b0, txRequest}, {31'b0, VEC[i].req});
      check($sformatf("R10 irq row %0d", i), {31'b0, irq}, {31'b0, VEC[i].irq});
    end

    // R3 geometry locked outside configuration mode
    step(1'b1, 32'h00012A3F, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 locked fields", ctrlRd, 32'h00012B1A);
    check("R2 payload 16", {25'b0, payloadBytes}, 32'd16);
    step(1'b1, 32'h00012B1F, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 payload 64", {25'b0, payloadBytes}, 32'd64);
    step(1'b1, 32'h00012B1C, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 payload 24", {25'b0, payloadBytes}, 32'd24);
    step(1'b1, 32'h00012B1A, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 config write accepted", ctrlRd, 32'h00012B1A);

    // R7 abort by writing request 0
    step(1'b1, 32'h00892B1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h00412B1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 request set", {31'b0, txRequest}, 32'd1);
    step(1'b1, 32'h00012B1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 abort pulse", {30'b0, abortReq, txRequest}, 32'b10);
    idle();
    check("R7 abort is one cycle", {31'b0, abortReq}, 32'd0);

    // R9 three retries
    step(1'b1, 32'h00412B1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
      check("R9 retry kept", {30'b0, txRequest, exhaustedFlag}, 32'b10);
    end
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 fourth failure ends", {30'b0, txRequest, exhaustedFlag}, 32'b01);

    // R5 reset command clears queue and flags
    step(1'b1, 32'h00212B1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 reset bit reads 1", {31'b0, ctrlRd[21]}, 32'd1);
    idle();
    check("R5 cleared", {25'b0, ctrlRd[21], exhaustedFlag, occupancy}, 32'd0);

    // R9 zero retries, then unlimited
    step(1'b1, 32'h0089291A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 32'h0041291A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 zero retry ends", {30'b0, txRequest, exhaustedFlag}, 32'b01);
    step(1'b1, 32'h00412D1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R9 unlimited retries", {31'b0, txRequest}, 32'd1);
    step(1'b0, 32'h0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 drain clears request", {25'b0, txRequest, occupancy}, 32'd0);

    // R8 remote frame
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 disabled auto-reply", {31'b0, txRequest}, 32'd0);
    step(1'b1, 32'h01012D1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 auto-reply sets request", {31'b0, txRequest}, 32'd1);
    step(1'b1, 32'h01012D1A, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 second abort", {30'b0, abortReq, txRequest}, 32'b10);

    // receive queue, depth 2, full interrupt enabled
    step(1'b1, 32'h00010608, 3'b100, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R2 payload 8", {25'b0, payloadBytes}, 32'd8);
    step(1'b1, 32'h00210608, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    idle();
    check("R5 rx queue cleared", {26'b0, occupancy}, 32'd0);
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R12 half at one of two", {29'b0, statusHalf, statusEmpty, irq}, 32'b100);
    check("R1 rx head moved", {27'b0, headIdx}, 32'd1);
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 full interrupt in rx", {30'b0, statusFull, irq}, 32'b11);
    step(1'b0, 32'h0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R11 overflow drop", {24'b0, overflowFlag, headIdx, occupancy[1:0]}, {24'b0, 1'b1, 5'd0, 2'd2});
    step(1'b1, 32'h00810608, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 rx strobe moves tail", {24'b0, tailIdx, occupancy[1:0], irq}, {24'b0, 5'd1, 2'd1, 1'b0});
    step(1'b1, 32'h00410608, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 request ignored in rx", {31'b0, txRequest}, 32'd0);

    finish();
  end
endmodule